// File: doc/BRIEF.md
# Block Lock Write-Protect Checker

This block sits beside a flash program/erase controller and decides whether each requested program or erase may proceed. It turns a word address into the index of the erase block that holds it, keeps one lock bit per block, and combines that bit with a master write-protect input. The array is made of a small-block region (`NUM_SMALL` blocks of `2**SMALL_LOG2` words) and a large-block region (`NUM_BIG` blocks of `2**BIG_LOG2` words). The parameter `BOOT_TOP` chooses whether the small-block region sits at the low or the high end of the address space.

The controller presents a request (address plus a program/erase flag). One cycle later the checker answers with allow or deny. A denial carries a block-status error flag and a flag for the kind of operation that was refused. The controller also reports completed erases, which unlock the erased block, and issues lock strobes, which lock a block. Lock bits start from the `INIT_LOCK` parameter.

Blocks are numbered in rising address order starting at 0. Lock bit value 1 means the block is unlocked and 0 means it is locked. Bit i of `INIT_LOCK` belongs to block i.

Top module: `blk_lock_guard`

## Requirements
- R1: While `rstN` is low and on the cycle after it rises, all response outputs are 0. Lock bit i takes the value of `INIT_LOCK[i]`.
- R2: With `BOOT_TOP`=0, an address a below `NUM_SMALL<<SMALL_LOG2` maps to block `a>>SMALL_LOG2`. Any other address maps to block `NUM_SMALL + ((a - (NUM_SMALL<<SMALL_LOG2))>>BIG_LOG2)`.
- R3: With `BOOT_TOP`=1, an address a below `NUM_BIG<<BIG_LOG2` maps to block `a>>BIG_LOG2`. Any other address maps to block `NUM_BIG + ((a - (NUM_BIG<<BIG_LOG2))>>SMALL_LOG2)`.
- R4: `respValid` is 1 exactly in the cycle after a cycle with `reqValid` high, and 0 otherwise.
- R5: When `masterWp` is 1, every request is allowed whatever the lock bit.
- R6: When `masterWp` is 0, a request is allowed if the addressed block's lock bit is 1 and refused if it is 0.
- R7: A refused request sets `errBlock` and sets `errErase` (when `reqErase`=1) or `errProgram` (when `reqErase`=0). An allowed request, and any cycle without a response, leaves all three flags at 0.
- R8: `eraseDone` sets the lock bit of the block holding `eraseAddr` to 1 and leaves every other block unchanged. Requests from the next cycle on see the new value.
- R9: `setLock` clears the lock bit of the block holding `lockAddr` to 0. Requests from the next cycle on see the new value.
- R10: If `setLock` and `eraseDone` name the same block in one cycle, the block ends up locked. A request in that same cycle is judged on the lock bit as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Operation request strobe |
| reqErase | input | 1 | 1 = erase request, 0 = program request |
| reqAddr | input | ADDR_W | Word address of the request |
| masterWp | input | 1 | Master write protect; 1 overrides all lock bits |
| eraseDone | input | 1 | A block erase has completed |
| eraseAddr | input | ADDR_W | Address inside the erased block |
| setLock | input | 1 | Lock strobe |
| lockAddr | input | ADDR_W | Address inside the block to lock |
| respValid | output | 1 | Response present |
| respAllow | output | 1 | Request may proceed |
| errBlock | output | 1 | Block-status error on refusal |
| errErase | output | 1 | Refused request was an erase |
| errProgram | output | 1 | Refused request was a program |

## Verification
Every response is due on the first rising edge after its request. A lock update takes effect at the same edge that records it, so a request placed in the following cycle already sees the new lock state. The bench drives inputs on the falling edge and reads the response on the next falling edge, one full edge after the request is sampled. Its lock model is updated only after the response for a same-cycle request has been compared, so R10's old-value rule is checked in the right order.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  // Strobes from the decision logic to the lock/response datapath.
  typedef struct packed {
    logic respLoad;   // a request is being answered
    logic allow;      // answer is allow
    logic errBlk;     // block-status error
    logic errEra;     // refused erase
    logic errPrg;     // refused program
    logic relWe;      // release (unlock) the erased block
    logic lockWe;     // lock the addressed block
  } ctrlStrobe_t;

endpackage

// File: rtl/blk_map.sv
// Address to block-index decoder for one address stream.
module blk_map #(
  parameter int NUM_SMALL  = 8,
  parameter int NUM_BIG    = 28,
  parameter int SMALL_LOG2 = 14,
  parameter int BIG_LOG2   = 15,
  parameter bit BOOT_TOP   = 1'b0,
  parameter int ADDR_W     = 20,
  parameter int IDX_W      = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] SMALL_SPAN = ADDR_W'(NUM_SMALL << SMALL_LOG2);
  localparam logic [ADDR_W-1:0] BIG_SPAN   = ADDR_W'(NUM_BIG << BIG_LOG2);

  logic [ADDR_W-1:0] rawIdx;

  generate
    if (BOOT_TOP) begin : g_top
      // large blocks first, small blocks at the high end
      always_comb begin
        if (addr < BIG_SPAN) rawIdx = addr >> BIG_LOG2;
        else rawIdx = ADDR_W'(NUM_BIG) + ((addr - BIG_SPAN) >> SMALL_LOG2);
      end
    end else begin : g_bottom
      // small blocks first, large blocks above
      always_comb begin
        if (addr < SMALL_SPAN) rawIdx = addr >> SMALL_LOG2;
        else rawIdx = ADDR_W'(NUM_SMALL) + ((addr - SMALL_SPAN) >> BIG_LOG2);
      end
    end
  endgenerate

  assign idx = IDX_W'(rawIdx);

endmodule

// File: rtl/blk_lock_ctrl.sv
// Decision logic: allow/deny and lock-update priority.
module blk_lock_ctrl
  import blk_lock_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqErase,
  input  logic        masterWp,
  input  logic        reqLockBit,
  input  logic        eraseDone,
  input  logic        setLock,
  input  logic        sameBlock,
  output ctrlStrobe_t strobe
);

  logic grant;
  logic refuse;

  assign grant  = reqValid & (masterWp | reqLockBit);
  assign refuse = reqValid & ~(masterWp | reqLockBit);

  always_comb begin
    strobe          = '0;
    strobe.respLoad = reqValid;
    strobe.allow    = grant;
    strobe.errBlk   = refuse;
    strobe.errEra   = refuse & reqErase;
    strobe.errPrg   = refuse & ~reqErase;
    strobe.lockWe   = setLock;
    // a lock strobe on the same block wins over an erase release
    strobe.relWe    = eraseDone & ~(setLock & sameBlock);
  end

endmodule

// File: rtl/blk_lock_dp.sv
// Lock bit array and registered response.
module blk_lock_dp
  import blk_lock_pkg::*;
#(
  parameter int                 NUM_BLK   = 36,
  parameter int                 IDX_W     = 6,
  parameter logic [NUM_BLK-1:0] INIT_LOCK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [IDX_W-1:0]  relIdx,
  input  logic [IDX_W-1:0]  lockIdx,
  output logic              reqLockBit,
  output logic              sameBlock,
  output logic              respValid,
  output logic              respAllow,
  output logic              errBlock,
  output logic              errErase,
  output logic              errProgram
);

  logic [NUM_BLK-1:0] lockBits;

  generate
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lockBits[i] <= INIT_LOCK[i];
        else if (strobe.lockWe && int'(lockIdx) == i) lockBits[i] <= 1'b0;
        else if (strobe.relWe && int'(relIdx) == i) lockBits[i] <= 1'b1;
      end
    end
  endgenerate

  // an index past the last block reads as locked
  assign reqLockBit = (int'(reqIdx) < NUM_BLK) ? lockBits[reqIdx] : 1'b0;
  assign sameBlock  = (relIdx == lockIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respAllow  <= 1'b0;
      errBlock   <= 1'b0;
      errErase   <= 1'b0;
      errProgram <= 1'b0;
    end else begin
      respValid  <= strobe.respLoad;
      respAllow  <= strobe.allow;
      errBlock   <= strobe.errBlk;
      errErase   <= strobe.errEra;
      errProgram <= strobe.errPrg;
    end
  end

endmodule

// File: rtl/blk_lock_guard.sv
// Top: three address decoders, decision logic, lock datapath.
module blk_lock_guard
  import blk_lock_pkg::*;
#(
  parameter int                 NUM_SMALL  = 8,
  parameter int                 NUM_BIG    = 28,
  parameter int                 SMALL_LOG2 = 14,
  parameter int                 BIG_LOG2   = 15,
  parameter bit                 BOOT_TOP   = 1'b0,
  parameter int                 NUM_BLK    = NUM_SMALL + NUM_BIG,
  parameter int                 ADDR_W     = $clog2((NUM_SMALL << SMALL_LOG2) + (NUM_BIG << BIG_LOG2)),
  parameter logic [NUM_BLK-1:0] INIT_LOCK  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              masterWp,
  input  logic              eraseDone,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic              setLock,
  input  logic [ADDR_W-1:0] lockAddr,
  output logic              respValid,
  output logic              respAllow,
  output logic              errBlock,
  output logic              errErase,
  output logic              errProgram
);

  localparam int IDX_W   = $clog2(NUM_BLK);
  localparam int N_PORTS = 3;   // request, erase-done, lock

  logic [N_PORTS-1:0][ADDR_W-1:0] mapAddr;
  logic [N_PORTS-1:0][IDX_W-1:0]  mapIdx;
  logic                           reqLockBit;
  logic                           sameBlock;
  ctrlStrobe_t                    strobe;

  assign mapAddr[0] = reqAddr;
  assign mapAddr[1] = eraseAddr;
  assign mapAddr[2] = lockAddr;

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
      blk_map #(
        .NUM_SMALL (NUM_SMALL),
        .NUM_BIG   (NUM_BIG),
        .SMALL_LOG2(SMALL_LOG2),
        .BIG_LOG2  (BIG_LOG2),
        .BOOT_TOP  (BOOT_TOP),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
      ) u_map (
        .addr(mapAddr[p]),
        .idx (mapIdx[p])
      );
    end
  endgenerate

  blk_lock_ctrl u_ctrl (
    .reqValid  (reqValid),
    .reqErase  (reqErase),
    .masterWp  (masterWp),
    .reqLockBit(reqLockBit),
    .eraseDone (eraseDone),
    .setLock   (setLock),
    .sameBlock (sameBlock),
    .strobe    (strobe)
  );

  blk_lock_dp #(
    .NUM_BLK  (NUM_BLK),
    .IDX_W    (IDX_W),
    .INIT_LOCK(INIT_LOCK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqIdx    (mapIdx[0]),
    .relIdx    (mapIdx[1]),
    .lockIdx   (mapIdx[2]),
    .reqLockBit(reqLockBit),
    .sameBlock (sameBlock),
    .respValid (respValid),
    .respAllow (respAllow),
    .errBlock  (errBlock),
    .errErase  (errErase),
    .errProgram(errProgram)
  );

endmodule

// File: rtl/blk_lock_guard_chk.sv
// Port-level properties of blk_lock_guard.
module blk_lock_guard_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqErase,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              masterWp,
  input logic              eraseDone,
  input logic [ADDR_W-1:0] eraseAddr,
  input logic              setLock,
  input logic [ADDR_W-1:0] lockAddr,
  input logic              respValid,
  input logic              respAllow,
  input logic              errBlock,
  input logic              errErase,
  input logic              errProgram
);

  p_resp_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  p_wp_override_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && masterWp) |=> respAllow);

  p_deny_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAllow) |-> (errBlock && (errErase != errProgram)));

  p_clean_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (respAllow || !respValid) |-> (!errBlock && !errErase && !errProgram));

  p_erase_kind_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqErase) |=> !errProgram);

  p_prog_kind_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqErase) |=> !errErase);

  p_locked_deny_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !masterWp && !eraseDone && $past(setLock) && reqAddr == $past(lockAddr))
      |=> !respAllow);

  p_release_allow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !setLock && $past(eraseDone) && !$past(setLock) && reqAddr == $past(eraseAddr))
      |=> respAllow);

endmodule

bind blk_lock_guard blk_lock_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_blk_lock_guard.sv
module test_blk_lock_guard;

  localparam int NS   = 8;
  localparam int NB   = 28;
  localparam int SL   = 2;
  localparam int BL   = 3;
  localparam int NBLK = NS + NB;
  localparam int AW   = 8;
  localparam int NADR = 256;
  localparam logic [NBLK-1:0] INIT = 36'h5_5555_5555;  // even blocks unlocked

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqErase = 1'b0, masterWp = 1'b0;
  logic [AW-1:0] reqAddr = '0, eraseAddr = '0, lockAddr = '0;
  logic          eraseDone = 1'b0, setLock = 1'b0;
  logic [4:0]    outB, outT;
  logic [NBLK-1:0] mB, mT;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blk_lock_guard #(
    .NUM_SMALL(NS), .NUM_BIG(NB), .SMALL_LOG2(SL), .BIG_LOG2(BL),
    .BOOT_TOP(1'b0), .INIT_LOCK(INIT)
  ) i_blk_lock_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqErase(reqErase), .reqAddr(reqAddr),
    .masterWp(masterWp), .eraseDone(eraseDone), .eraseAddr(eraseAddr),
    .setLock(setLock), .lockAddr(lockAddr),
    .respValid(outB[4]), .respAllow(outB[3]), .errBlock(outB[2]),
    .errErase(outB[1]), .errProgram(outB[0])
  );

  blk_lock_guard #(
    .NUM_SMALL(NS), .NUM_BIG(NB), .SMALL_LOG2(SL), .BIG_LOG2(BL),
    .BOOT_TOP(1'b1), .INIT_LOCK(INIT)
  ) i_blk_lock_guard_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqErase(reqErase), .reqAddr(reqAddr),
    .masterWp(masterWp), .eraseDone(eraseDone), .eraseAddr(eraseAddr),
    .setLock(setLock), .lockAddr(lockAddr),
    .respValid(outT[4]), .respAllow(outT[3]), .errBlock(outT[2]),
    .errErase(outT[1]), .errProgram(outT[0])
  );

  function automatic int idxB(int a);
    if (a < (NS << SL)) return a >> SL;
    return NS + ((a - (NS << SL)) >> BL);
  endfunction

  function automatic int idxT(int a);
    if (a < (NB << BL)) return a >> BL;
    return NB + ((a - (NB << BL)) >> SL);
  endfunction

  // {respValid, respAllow, errBlock, errErase, errProgram}
  function automatic logic [4:0] expResp(logic lockBit, logic wp, logic er);
    logic ok;
    ok = wp | lockBit;
    return {1'b1, ok, ~ok, ~ok & er, ~ok & ~er};
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the response
  task automatic request(int a, logic er, logic wp, string tag);
    logic [4:0] eB, eT;
    reqValid = 1'b1; reqAddr = AW'(a); reqErase = er; masterWp = wp;
    eB = expResp(mB[idxB(a)], wp, er);
    eT = expResp(mT[idxT(a)], wp, er);
    @(negedge clk);
    check($sformatf("%s bottom addr=%0d", tag, a), outB, eB);
    check($sformatf("%s top addr=%0d", tag, a), outT, eT);
    reqValid = 1'b0;
  endtask

  task automatic eraseAt(int a);
    eraseDone = 1'b1; eraseAddr = AW'(a);
    @(negedge clk);
    eraseDone = 1'b0;
    mB[idxB(a)] = 1'b1;
    mT[idxT(a)] = 1'b1;
  endtask

  task automatic lockAt(int a);
    setLock = 1'b1; lockAddr = AW'(a);
    @(negedge clk);
    setLock = 1'b0;
    mB[idxB(a)] = 1'b0;
    mT[idxT(a)] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int eList[7];
    eList = '{0, 5, 31, 32, 40, 130, 255};
    mB = INIT;
    mT = INIT;
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    check("R1 reset bottom", outB, 5'b0);
    check("R1 reset top", outT, 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset bottom", outB, 5'b0);
    check("R1 after reset top", outT, 5'b0);

    // R2 R3 R6: initial pattern seen at every address in both placements
    for (int a = 0; a < NADR; a++) request(a, 1'b0, 1'b0, "R2 R3 R6 sweep");

    // R5: master write protect high allows everything
    for (int a = 0; a < NADR; a++) request(a, 1'b1, 1'b1, "R5 override");

    // R4: no response in an idle cycle
    @(negedge clk);
    check("R4 idle bottom", outB, 5'b0);
    check("R4 idle top", outT, 5'b0);

    // R9: lock every block (smallest block is 4 words)
    for (int a = 0; a < NADR; a += 4) lockAt(a);
    for (int a = 0; a < NADR; a++) request(a, 1'b1, 1'b0, "R9 R7 locked erase");
    for (int a = 0; a < NADR; a += 3) request(a, 1'b0, 1'b0, "R9 R7 locked program");

    // R8: each erase releases only its own block
    foreach (eList[k]) begin
      eraseAt(eList[k]);
      for (int a = 0; a < NADR; a++) request(a, a[0], 1'b0, "R8 release");
    end

    // R10: lock and release on the same block plus a request in one cycle
    eraseAt(100);
    request(100, 1'b0, 1'b0, "R8 unlocked before R10");
    setLock = 1'b1; lockAddr = AW'(100);
    eraseDone = 1'b1; eraseAddr = AW'(101);
    request(100, 1'b1, 1'b0, "R10 same-cycle request sees old bit");
    setLock = 1'b0; eraseDone = 1'b0;
    mB[idxB(100)] = 1'b0;
    mT[idxT(100)] = 1'b0;
    request(100, 1'b1, 1'b0, "R10 lock wins");
    request(101, 1'b0, 1'b0, "R10 lock wins neighbour address");
    request(100, 1'b0, 1'b1, "R5 override on locked block");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule